// File: doc/BRIEF.md
# PIPE Signaling-Rate Switch Sequencer

This block manages a move between the 2.5 Gbps and 5 Gbps PCI Express signaling rates for a group of bonded lanes. It watches a rate-select level from the MAC side. Each change of that level, whether rising or falling, starts one switch. For each switch the block asks an external clock divider to retime the low-speed parallel clock. A Gen2 switch takes that clock from 250 MHz to 500 MHz and the fabric clock from 125 MHz to 250 MHz, and a Gen1 switch reverses both. The block then waits for the divider to say it is finished.

When the divider finishes, the block raises a done-status strobe on every bonded lane in the same cycle, for one cycle only. A current-rate register changes in that same cycle. These outputs feed the PIPE interface logic, which passes them on to the PHY-MAC layer.

The select level may change again while a switch is still running. Such changes are queued and handled one at a time, so each change gets its own strobe. A watchdog counter raises an error flag if the divider takes too long.

Top module: `pipe_rate_switch_ctrl`

## Requirements
- R1: After reset the block is idle at the Gen1 rate: `cur_rate`=0, `lane_done`=0, `div_req`=0, `timeout_err`=0.
- R2: When the block is idle, a change of `rate_sel` in either direction raises `div_req` on the fourth rising clock edge after the new level is applied, and not before. Two edges are for synchronization, one detects the change and one starts the request. While `div_req` is high, `div_rate` gives the target rate (0 = Gen1, 1 = Gen2), which differs from `cur_rate`.
- R3: `div_req` stays high until `div_done` is sampled high while the block waits for the divider. `div_req` falls in the cycle where the done strobe appears.
- R4: Completion drives all NUM_LANES bits of `lane_done` high together for exactly one clock cycle.
- R5: `cur_rate` takes the new rate (0 = Gen1, 1 = Gen2) in the cycle where `lane_done` is high, and does not change at any other time.
- R6: Each change of `rate_sel` produces its own strobe. Changes that arrive during a switch are queued, up to PEND_DEPTH of them, and handled in arrival order after the current strobe. The rates therefore alternate and follow the select level.
- R7: If `div_done` has not arrived after TIMEOUT_CYCLES cycles of waiting, `timeout_err` goes high. The block keeps waiting, and the flag stays high until the next request begins.
- R8: A `div_done` that arrives while no request is pending has no effect: no strobe appears and `cur_rate` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parallel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rate_sel | input | 1 | Asynchronous rate-select level (0 = Gen1, 1 = Gen2) |
| div_done | input | 1 | Clock divider reports that the switch is complete |
| div_req | output | 1 | Request to the clock divider to switch |
| div_rate | output | 1 | Target rate of the current request |
| lane_done | output | NUM_LANES | One-cycle done-status strobe, one bit per bonded lane |
| cur_rate | output | 1 | Rate currently in effect |
| timeout_err | output | 1 | The divider did not answer within TIMEOUT_CYCLES |

## Verification
A wrong sequencer state shows up within a few cycles. It appears as a `div_req` that rises on the wrong edge, a request that never falls, or a strobe that lasts two cycles or covers only some lanes. Queue errors take longer to show: a lost or merged change leaves one fewer strobe than select changes once the switches have run out. A wrong target rate breaks the alternation of `cur_rate` at the next strobe. Timeout counting errors show as the flag rising a few cycles early or late compared with the request edge.

// File: rtl/rs_pkg.sv
// Shared types for the rate switch sequencer.
// Assumes rate encoding 0 = Gen1, 1 = Gen2.
package rs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_REQUEST   = 2'd1,
        ST_WAIT_DONE = 2'd2,
        ST_PULSE     = 2'd3
    } rs_state_e;

    localparam logic RATE_GEN1 = 1'b0;
    localparam logic RATE_GEN2 = 1'b1;
endpackage

// File: rtl/rs_edge_sync.sv
// Brings an asynchronous level into the clock domain and flags each change.
// Assumes STAGES >= 2 and that the level resets to 0 (Gen1).
module rs_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic toggle
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    // Shift the async level through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], din};
    end

    // Remember the last synchronized level for change detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign level  = chain_q[STAGES-1];
    assign toggle = chain_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/rs_pend_count.sv
// Counts rate-select changes that have not yet been serviced.
// Assumes dec is only asserted when nonempty; saturates at DEPTH.
module rs_pend_count #(
    parameter int DEPTH = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    output logic nonempty
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic [CW-1:0] cnt_q;
    logic          can_inc;

    assign can_inc = inc && (cnt_q != FULL);

    // Track outstanding requests; simultaneous inc and dec cancel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (can_inc && !dec) begin
            cnt_q <= cnt_q + 1'b1;
        end else if (dec && !inc) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign nonempty = (cnt_q != '0);
endmodule

// File: rtl/rs_timeout.sv
// Watches the wait for the divider and flags a late completion.
// Assumes start marks the beginning of each new request.
module rs_timeout #(
    parameter int LIMIT  = 4096,
    parameter bit ENABLE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic waiting,
    input  logic start,
    output logic err
);
    generate
        if (ENABLE) begin : g_on
            localparam int TW = $clog2(LIMIT + 1);
            localparam logic [TW-1:0] LAST = TW'(LIMIT - 1);
            logic [TW-1:0] cnt_q;
            logic          err_q;

            // Count cycles spent waiting for the divider.
            always_ff @(posedge clk) begin
                if (!rst_n || start)         cnt_q <= '0;
                else if (waiting && !err_q)  cnt_q <= cnt_q + 1'b1;
            end

            // Raise the flag at the limit; clear it when a new request begins.
            always_ff @(posedge clk) begin
                if (!rst_n || start)                   err_q <= 1'b0;
                else if (waiting && cnt_q == LAST)     err_q <= 1'b1;
            end

            assign err = err_q;
        end else begin : g_off
            logic unused_inputs;
            assign unused_inputs = ^{clk, rst_n, waiting, start};
            assign err = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/pipe_rate_switch_ctrl.sv
// Sequences a Gen1/Gen2 switch: select change -> divider request ->
// divider done -> one-cycle done strobe on all bonded lanes.
// Assumes div_done is synchronous to clk and held until div_req falls.
module pipe_rate_switch_ctrl #(
    parameter int NUM_LANES      = 4,
    parameter int SYNC_STAGES    = 2,
    parameter int PEND_DEPTH     = 3,
    parameter int TIMEOUT_CYCLES = 4096,
    parameter bit TIMEOUT_EN     = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rate_sel,
    input  logic                 div_done,
    output logic                 div_req,
    output logic                 div_rate,
    output logic [NUM_LANES-1:0] lane_done,
    output logic                 cur_rate,
    output logic                 timeout_err
);
    import rs_pkg::*;

    rs_state_e            state_q, state_d;
    logic                 sel_level, sel_toggle;
    logic                 pend_nonempty, start, finish;
    logic                 tgt_q, rate_q;
    logic [NUM_LANES-1:0] done_q;

    rs_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(rate_sel),
        .level(sel_level), .toggle(sel_toggle)
    );

    rs_pend_count #(.DEPTH(PEND_DEPTH)) u_pend (
        .clk(clk), .rst_n(rst_n), .inc(sel_toggle), .dec(start),
        .nonempty(pend_nonempty)
    );

    rs_timeout #(.LIMIT(TIMEOUT_CYCLES), .ENABLE(TIMEOUT_EN)) u_tmo (
        .clk(clk), .rst_n(rst_n), .waiting(state_q == ST_WAIT_DONE),
        .start(start), .err(timeout_err)
    );

    logic unused_level;
    assign unused_level = sel_level;

    assign start  = (state_q == ST_IDLE) && pend_nonempty;
    assign finish = (state_q == ST_WAIT_DONE) && div_done;

    // Next-state logic for the switch sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (start)  state_d = ST_REQUEST;
            ST_REQUEST:               state_d = ST_WAIT_DONE;
            ST_WAIT_DONE: if (finish) state_d = ST_PULSE;
            ST_PULSE:                 state_d = ST_IDLE;
            default:                  state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Capture the target rate as the opposite of the current one at start.
    always_ff @(posedge clk) begin
        if (!rst_n)     tgt_q <= RATE_GEN1;
        else if (start) tgt_q <= ~rate_q;
    end

    // Commit the new rate together with the done strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      rate_q <= RATE_GEN1;
        else if (finish) rate_q <= tgt_q;
    end

    // Drive the one-cycle strobe on every bonded lane at once.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= '0;
        else        done_q <= {NUM_LANES{finish}};
    end

    assign div_req   = (state_q == ST_REQUEST) || (state_q == ST_WAIT_DONE);
    assign div_rate  = tgt_q;
    assign cur_rate  = rate_q;
    assign lane_done = done_q;
endmodule

// Port-level properties of the rate switch sequencer.
module rs_ctrl_checker #(
    parameter int NUM_LANES = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 div_done,
    input logic                 div_req,
    input logic                 div_rate,
    input logic [NUM_LANES-1:0] lane_done,
    input logic                 cur_rate
);
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (lane_done == '0 && !div_req && !cur_rate));

    p_target_differs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        div_req |-> (div_rate != cur_rate));

    p_req_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (div_req && !div_done) |=> div_req);

    p_req_drop_with_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(div_req) |-> (lane_done == {NUM_LANES{1'b1}}));

    p_all_lanes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_done == '0) || (lane_done == {NUM_LANES{1'b1}}));

    p_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_done != '0) |=> (lane_done == '0));

    p_rate_moves_on_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_done != '0) |-> (cur_rate != $past(cur_rate)));

    p_rate_still_otherwise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_done == '0) |-> $stable(cur_rate));

    p_strobe_needs_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_done != '0) |-> ($past(div_done) && $past(div_req)));
endmodule

bind pipe_rate_switch_ctrl rs_ctrl_checker #(.NUM_LANES(NUM_LANES)) u_chk (
    .clk(clk), .rst_n(rst_n), .div_done(div_done), .div_req(div_req),
    .div_rate(div_rate), .lane_done(lane_done), .cur_rate(cur_rate)
);

// File: tb/sim_pipe_rate_switch_ctrl.sv
module sim_pipe_rate_switch_ctrl;
    localparam int LANES = 4;
    localparam int TMO   = 20;
    localparam int WATCHDOG = 100000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             rate_sel = 1'b0;
    logic             div_done, div_req, div_rate, cur_rate, timeout_err;
    logic [LANES-1:0] lane_done;

    // Divider stand-in
    int   model_lat = 3;
    bit   model_hold = 1'b0;
    logic model_done;
    int   model_cnt;
    logic stray_done = 1'b0;

    int checks = 0, failures = 0, pulses = 0, cycles = 0;
    bit finished = 1'b0;
    bit exp_q[$];
    bit prev_pulse = 1'b0;

    always #10 clk = ~clk;

    pipe_rate_switch_ctrl #(
        .NUM_LANES(LANES), .SYNC_STAGES(2), .PEND_DEPTH(3),
        .TIMEOUT_CYCLES(TMO), .TIMEOUT_EN(1'b1)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .div_done(div_done),
        .div_req(div_req), .div_rate(div_rate), .lane_done(lane_done),
        .cur_rate(cur_rate), .timeout_err(timeout_err)
    );

    assign div_done = model_done | stray_done;

    always_ff @(posedge clk) begin
        if (!rst_n || !div_req) begin
            model_done <= 1'b0;
            model_cnt  <= 0;
        end else if (!model_hold) begin
            if (model_cnt >= model_lat) model_done <= 1'b1;
            else                        model_cnt  <= model_cnt + 1;
        end
    end

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Driver: flip the select level and push the expected rate.
    task automatic toggle_rate();
        @(negedge clk);
        rate_sel = ~rate_sel;
        exp_q.push_back(rate_sel);
    endtask

    task automatic drain();
        for (int i = 0; i < 3000; i++) begin
            if (exp_q.size() == 0 && !div_req) break;
            tick(1);
        end
        tick(3);
        check(exp_q.size() == 0, "R6", "pending strobes left", exp_q.size(), 0);
    endtask

    // Monitor: pop and compare each strobe.
    always @(negedge clk) begin
        if (rst_n) begin
            if (lane_done != '0) begin
                pulses++;
                check(!prev_pulse, "R4", "strobe longer than one cycle", 2, 1);
                check(lane_done == {LANES{1'b1}}, "R4", "lane_done", lane_done, {LANES{1'b1}});
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8", "unexpected strobe", 1, 0);
                end else begin
                    automatic bit e = exp_q.pop_front();
                    check(cur_rate == e, "R5", "cur_rate at strobe", cur_rate, e);
                end
            end
            prev_pulse = (lane_done != '0);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !finished) begin
            check(1'b0, "WATCHDOG", "timeout", cycles, WATCHDOG);
            report();
        end
    end

    initial begin
        int base;
        tick(3);
        // R1 reset state
        check(lane_done == '0, "R1", "lane_done in reset", lane_done, 0);
        check(!div_req, "R1", "div_req in reset", div_req, 0);
        rst_n = 1'b1;
        tick(2);
        check(cur_rate == 1'b0, "R1", "cur_rate after reset", cur_rate, 0);
        check(!timeout_err, "R1", "timeout_err after reset", timeout_err, 0);
        check(!div_req, "R1", "div_req after reset", div_req, 0);

        // R2 latency to request, Gen1 -> Gen2
        toggle_rate();
        tick(3);
        check(!div_req, "R2", "div_req early", div_req, 0);
        tick(1);
        check(div_req, "R2", "div_req on 4th edge", div_req, 1);
        check(div_rate == 1'b1, "R2", "div_rate to Gen2", div_rate, 1);
        // R3 request held while divider busy
        tick(2);
        check(div_req, "R3", "div_req held", div_req, 1);
        drain();
        check(cur_rate == 1'b1, "R5", "rate after first switch", cur_rate, 1);
        check(!div_req, "R3", "div_req dropped", div_req, 0);

        // R2 falling direction, Gen2 -> Gen1
        toggle_rate();
        tick(4);
        check(div_req && div_rate == 1'b0, "R2", "request to Gen1", div_rate, 0);
        drain();
        check(cur_rate == 1'b0, "R5", "rate back to Gen1", cur_rate, 0);

        // R6 toggles during a switch are queued, each gets a strobe
        model_lat = 12;
        base = pulses;
        toggle_rate();
        tick(6);
        toggle_rate();
        tick(2);
        toggle_rate();
        drain();
        check(pulses - base == 3, "R6", "strobes for three toggles", pulses - base, 3);
        check(cur_rate == 1'b1, "R6", "final rate follows select", cur_rate, 1);

        // R6 zero divider latency
        model_lat = 0;
        toggle_rate();
        drain();
        check(cur_rate == 1'b0, "R6", "rate with zero latency", cur_rate, 0);

        // R8 stray done while idle
        base = pulses;
        @(negedge clk); stray_done = 1'b1;
        tick(3);
        stray_done = 1'b0;
        tick(3);
        check(pulses == base, "R8", "strobes from stray done", pulses - base, 0);
        check(cur_rate == 1'b0, "R8", "rate after stray done", cur_rate, 0);

        // R7 timeout
        model_hold = 1'b1;
        toggle_rate();
        tick(4);
        check(div_req, "R7", "request started", div_req, 1);
        tick(TMO - 3);
        check(!timeout_err, "R7", "flag early", timeout_err, 0);
        tick(6);
        check(timeout_err, "R7", "flag after limit", timeout_err, 1);
        check(div_req, "R7", "still waiting", div_req, 1);
        @(negedge clk); stray_done = 1'b1;
        @(negedge clk); stray_done = 1'b0;
        drain();
        check(cur_rate == 1'b1, "R7", "rate after late done", cur_rate, 1);
        check(timeout_err, "R7", "flag stays until next request", timeout_err, 1);
        model_hold = 1'b0;
        model_lat = 2;
        toggle_rate();
        tick(4);
        check(!timeout_err, "R7", "flag cleared at new request", timeout_err, 0);
        drain();
        check(cur_rate == 1'b0, "R5", "final rate", cur_rate, 0);

        report();
    end
endmodule